// File: doc/BRIEF.md
# Carrier Interrupt Control-Status Unit

This block is the interrupt front end of a carrier board that hosts up to four plug-in modules, each with two interrupt request lines. It holds one control byte per slot and a shared 16-bit status word. The eight module requests are merged into one host interrupt line. Each request line can be enabled or ignored, and can work in edge or level fashion.

A host reads and writes the registers through a plain 16-bit register port with one cycle of read latency. Requests arrive as level inputs and are handled as events: a rising input sets the status bit and a falling input clears it. When software or an acknowledge clears a request, the block pulses a per-line clear output back towards the module. The module-space decoder reports interrupt-space reads as acknowledge strobes. Timeout status bits are set from outside and cleared by software. Error bits always read zero. The clock-rate and recover control bits, and the reset register, are storage only.

Top module: `carrier_irq_ctl`

## Requirements
- R1: After a synchronous active-high reset, every control byte and the status word read 0, host_irq is low and req_clr is all zero.
- R2: The control bytes of slots 0..3 sit at byte offsets 0x2, 0x4, 0x6 and 0x8 and read back as {8'h00, byte}. Offsets 0x0 (revision) and 0xA (reset) read 0 and ignore writes. The status word sits at offset 0xC.
- R3: When a line's enable bit is clear (control bit 6 for line 0, bit 7 for line 1), a change of its request input leaves its status bit unchanged.
- R4: For an enabled line, status bit slot*2+line is set by a rising request and cleared by a falling request.
- R5: In edge mode (control bit 4 for line 0, bit 5 for line 1), a rising request that sets the status bit drives host_irq to the inverse of the sticky level flag for exactly one cycle, after which host_irq returns to the flag.
- R6: Otherwise host_irq equals the sticky flag. The flag is the OR of the status bits of the lines in level mode. It is recomputed on the same clock edge as a control-byte write.
- R7: Writing 1 to status bit slot*2+line clears that bit if the line is enabled, and pulses req_clr at that bit position for one cycle in either case.
- R8: Timeout bit 12+slot is set by a tmo_set pulse and cleared by writing 1 to it. Status bits 8..11 always read 0, and writing to them changes nothing.
- R9: An acknowledge at interrupt-space offset 0 or 2 targets line 0 or line 1 of ack_slot. It clears the status bit and pulses req_clr only if the bit is set and the line is in level mode. Acknowledges at other offsets, or on edge-mode lines, have no effect.
- R10: reg_rdata shows the register addressed by reg_addr on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| mod_req | input | 2*NUM_SLOTS | Module interrupt request levels, bit slot*2+line |
| ack_valid | input | 1 | Interrupt-space read strobe from the module decoder |
| ack_slot | input | $clog2(NUM_SLOTS) | Slot of the interrupt-space read |
| ack_off | input | OFF_W | Offset of the interrupt-space read |
| tmo_set | input | NUM_SLOTS | Per-slot timeout set pulse |
| req_clr | output | 2*NUM_SLOTS | One-cycle clear pulse towards each module request line |
| host_irq | output | 1 | Merged host interrupt |

## Verification
The hardest case to reach is an edge-mode pulse that fires while a level-mode line already holds the sticky flag high. Here the pulse appears as a one-cycle dip instead of a spike. The bench holds a level line active in slot 0, clears an edge line's status by software while its request stays high, drops that request and raises it again to fire a fresh edge event. Acknowledges on an edge-mode line are reached the same way: the line is first set up in level mode and then switched to edge mode before a new event.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  localparam int OFF_REV    = 0;
  localparam int OFF_CTRL0  = 2;
  localparam int OFF_RESET  = 10;
  localparam int OFF_STATUS = 12;
  localparam int CB_EDGE    = 4;   // edge select, +line
  localparam int CB_EN      = 6;   // line enable, +line
  localparam int ST_TMO     = 12;  // timeout bit base in status
  localparam int ACK_L0     = 0;
  localparam int ACK_L1     = 2;
  typedef logic [7:0] ctrl_byte_t;
endpackage

// File: rtl/ccs_ctrl_bank.sv
module ccs_ctrl_bank
  import ccs_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                we,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [7:0]                          wdata,
  output ctrl_byte_t [NUM_SLOTS-1:0]          ctrl_q,
  output logic [2*NUM_SLOTS-1:0]              en_q,
  output logic [2*NUM_SLOTS-1:0]              edge_q,
  output logic [2*NUM_SLOTS-1:0]              edge_d
);
  ctrl_byte_t [NUM_SLOTS-1:0] ctrl_d;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int MY_OFF = OFF_CTRL0 + 2*s;
    always_comb begin
      ctrl_d[s] = ctrl_q[s];
      if (we && (int'(addr) == MY_OFF)) ctrl_d[s] = wdata;
    end
    always_ff @(posedge clk) begin
      if (rst) ctrl_q[s] <= '0;
      else     ctrl_q[s] <= ctrl_d[s];
    end
    for (genvar l = 0; l < 2; l++) begin : g_line
      assign en_q[2*s+l]   = ctrl_q[s][CB_EN+l];
      assign edge_q[2*s+l] = ctrl_q[s][CB_EDGE+l];
      assign edge_d[2*s+l] = ctrl_d[s][CB_EDGE+l];
    end
  end
endmodule

// File: rtl/ccs_line_status.sv
module ccs_line_status #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] req_i,
  input  logic [NL-1:0] en_i,
  input  logic [NL-1:0] edge_i,
  input  logic [NL-1:0] clr_i,
  output logic [NL-1:0] status_q,
  output logic [NL-1:0] status_d,
  output logic          fire_o
);
  logic [NL-1:0] req_q;
  logic [NL-1:0] fire_v;

  for (genvar i = 0; i < NL; i++) begin : g_ln
    logic rise, fall;
    assign rise = req_i[i] & ~req_q[i];
    assign fall = ~req_i[i] & req_q[i];
    always_comb begin
      status_d[i] = status_q[i];
      if (en_i[i]) begin
        if (clr_i[i])  status_d[i] = 1'b0;
        else if (rise) status_d[i] = 1'b1;
        else if (fall) status_d[i] = 1'b0;
      end
    end
    assign fire_v[i] = en_i[i] & edge_i[i] & rise & ~clr_i[i] & ~status_q[i];

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
      !en_i[i] |=> status_q[i] == $past(status_q[i])); // R3
    AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
      (en_i[i] && rise && !clr_i[i]) |=> status_q[i]); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= '0;
      status_q <= '0;
    end else begin
      req_q    <= req_i;
      status_q <= status_d;
    end
  end
  assign fire_o = |fire_v;
endmodule

// File: rtl/ccs_irq_merge.sv
module ccs_irq_merge #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] status_d,
  input  logic [NL-1:0] edge_d,
  input  logic          fire,
  output logic          host_irq
);
  logic sticky_q;
  logic sticky_d;

  assign sticky_d = |(status_d & ~edge_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= 1'b0;
      host_irq <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      host_irq <= fire ? ~sticky_q : sticky_d;
    end
  end

  AST_PULSE_INVERT: assert property (@(posedge clk) disable iff (rst)
    fire |=> host_irq == !$past(sticky_q)); // R5
  AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !fire |=> host_irq == sticky_q); // R6
endmodule

// File: rtl/carrier_irq_ctl.sv
module carrier_irq_ctl
  import ccs_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 4,
  parameter int OFF_W     = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_we,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [15:0]                  reg_wdata,
  output logic [15:0]                  reg_rdata,
  input  logic [2*NUM_SLOTS-1:0]       mod_req,
  input  logic                         ack_valid,
  input  logic [$clog2(NUM_SLOTS)-1:0] ack_slot,
  input  logic [OFF_W-1:0]             ack_off,
  input  logic [NUM_SLOTS-1:0]         tmo_set,
  output logic [2*NUM_SLOTS-1:0]       req_clr,
  output logic                         host_irq
);
  localparam int NL = 2 * NUM_SLOTS;

  ctrl_byte_t [NUM_SLOTS-1:0] ctrl_q;
  logic [NL-1:0] en_q, edge_q, edge_d;
  logic [NL-1:0] status_q, status_d;
  logic [NL-1:0] wr_clr, ack_clr;
  logic [NUM_SLOTS-1:0] tmo_q;
  logic          fire;
  logic          wr_status;
  logic [15:0]   status_word;
  logic [15:0]   rd_d;

  assign wr_status = reg_we && (int'(reg_addr) == OFF_STATUS);
  assign wr_clr    = wr_status ? reg_wdata[NL-1:0] : '0;

  always_comb begin
    ack_clr = '0;
    if (ack_valid && (int'(ack_off) == ACK_L0 || int'(ack_off) == ACK_L1)) begin
      for (int i = 0; i < NL; i++) begin
        if (i == int'(ack_slot) * 2 + int'(ack_off[1]))
          ack_clr[i] = status_q[i] & ~edge_q[i];
      end
    end
  end

  ccs_ctrl_bank #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata[7:0]),
    .ctrl_q(ctrl_q), .en_q(en_q), .edge_q(edge_q), .edge_d(edge_d)
  );

  ccs_line_status #(.NL(NL)) u_stat (
    .clk(clk), .rst(rst), .req_i(mod_req), .en_i(en_q), .edge_i(edge_q),
    .clr_i(wr_clr | ack_clr), .status_q(status_q), .status_d(status_d),
    .fire_o(fire)
  );

  ccs_irq_merge #(.NL(NL)) u_merge (
    .clk(clk), .rst(rst), .status_d(status_d), .edge_d(edge_d),
    .fire(fire), .host_irq(host_irq)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_tmo
    always_ff @(posedge clk) begin
      if (rst) tmo_q[s] <= 1'b0;
      else     tmo_q[s] <= tmo_set[s] | (tmo_q[s] & ~(wr_status & reg_wdata[ST_TMO+s]));
    end
  end

  always_comb begin
    status_word = '0;
    status_word[NL-1:0] = status_q;
    for (int s = 0; s < NUM_SLOTS; s++) status_word[ST_TMO+s] = tmo_q[s];
  end

  always_comb begin
    rd_d = '0;
    if (int'(reg_addr) == OFF_STATUS) rd_d = status_word;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (int'(reg_addr) == OFF_CTRL0 + 2*s) rd_d = {8'h00, ctrl_q[s]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      req_clr   <= '0;
    end else begin
      reg_rdata <= rd_d;
      req_clr   <= wr_clr | ack_clr;
    end
  end

  AST_TMO_SET: assert property (@(posedge clk) disable iff (rst)
    (|tmo_set) |=> ((tmo_q & $past(tmo_set)) == $past(tmo_set))); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (|ack_clr) |=> ((req_clr & $past(ack_clr)) == $past(ack_clr))); // R9
endmodule

// File: tb/carrier_irq_ctl_test.sv
module carrier_irq_ctl_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [7:0]  mod_req;
  logic        ack_valid;
  logic [1:0]  ack_slot;
  logic [5:0]  ack_off;
  logic [3:0]  tmo_set;
  logic [7:0]  req_clr;
  logic        host_irq;
  logic [7:0]  clr_seen;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  carrier_irq_ctl uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mod_req(mod_req),
    .ack_valid(ack_valid), .ack_slot(ack_slot), .ack_off(ack_off),
    .tmo_set(tmo_set), .req_clr(req_clr), .host_irq(host_irq)
  );

  always @(negedge clk) clr_seen <= clr_seen | req_clr;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; reg_we = 0; reg_addr = 4'hC; reg_wdata = 0; mod_req = 0;
    ack_valid = 0; ack_slot = 0; ack_off = 0; tmo_set = 0; clr_seen = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic set_req(int bitn, logic v);
    @(negedge clk);
    mod_req[bitn] = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack(logic [1:0] s, logic [5:0] o);
    @(negedge clk);
    ack_valid = 1; ack_slot = s; ack_off = o;
    @(posedge clk);
    @(negedge clk);
    ack_valid = 0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    rd(4'hC, v); check("R1 status", v, 16'h0);
    rd(4'h2, v); check("R1 ctrl0", v, 16'h0);
    check("R1 host_irq", {15'b0, host_irq}, 16'h0);
    check("R1 req_clr", {8'b0, req_clr}, 16'h0);
  endtask

  task automatic t_map();
    logic [15:0] v;
    do_reset();
    wr(4'h2, 16'hABC3);
    wr(4'h8, 16'h00F1);
    wr(4'h0, 16'hFFFF);
    wr(4'hA, 16'hFFFF);
    rd(4'h2, v); check("R2 ctrl0 low byte", v, 16'h00C3);
    rd(4'h8, v); check("R2 ctrl3", v, 16'h00F1);
    rd(4'h0, v); check("R2 revision", v, 16'h0);
    rd(4'hA, v); check("R2 reset reg", v, 16'h0);
    // R10: before the edge the old value is still shown
    @(negedge clk); reg_addr = 4'h8; #0;
    check("R10 no early update", reg_rdata, 16'h0);
    @(posedge clk); @(negedge clk);
    check("R10 one-cycle read", reg_rdata, 16'h00F1);
  endtask

  task automatic t_disabled();
    logic [15:0] v;
    do_reset();
    wr(4'h4, 16'h0030);
    set_req(2, 1); set_req(3, 1);
    rd(4'hC, v); check("R3 disabled status", v, 16'h0);
    check("R3 disabled host", {15'b0, host_irq}, 16'h0);
  endtask

  task automatic t_level();
    logic [15:0] v;
    do_reset();
    wr(4'h2, 16'h0040);
    set_req(0, 1);
    check("R6 level host high", {15'b0, host_irq}, 16'h1);
    set_req(1, 1);
    rd(4'hC, v); check("R4 set bit0 only", v, 16'h0001);
    set_req(0, 0);
    check("R6 level host low", {15'b0, host_irq}, 16'h0);
    rd(4'hC, v); check("R4 fall clears", v, 16'h0000);
  endtask

  task automatic t_edge();
    logic [15:0] v;
    do_reset();
    wr(4'h6, 16'h00A0);          // slot2 line1 edge, status bit 5
    set_req(5, 1);
    check("R5 pulse high", {15'b0, host_irq}, 16'h1);
    @(negedge clk);
    check("R5 pulse restores", {15'b0, host_irq}, 16'h0);
    rd(4'hC, v); check("R4 edge status", v, 16'h0020);
    wr(4'hC, 16'h0020);
    rd(4'hC, v); check("R7 w1c edge bit", v, 16'h0);
    wr(4'h2, 16'h0040);
    set_req(0, 1);
    check("R6 sticky high", {15'b0, host_irq}, 16'h1);
    set_req(5, 0);
    set_req(5, 1);
    check("R5 inverted dip", {15'b0, host_irq}, 16'h0);
    @(negedge clk);
    check("R5 dip restores", {15'b0, host_irq}, 16'h1);
  endtask

  task automatic t_recompute();
    do_reset();
    wr(4'h2, 16'h0040);
    set_req(0, 1);
    wr(4'h2, 16'h0050);
    check("R6 recompute to edge", {15'b0, host_irq}, 16'h0);
    wr(4'h2, 16'h0040);
    check("R6 recompute to level", {15'b0, host_irq}, 16'h1);
  endtask

  task automatic t_w1c();
    logic [15:0] v;
    do_reset();
    wr(4'h2, 16'h0040);
    set_req(0, 1);
    clr_seen = 0;
    wr(4'hC, 16'h0001);
    @(negedge clk);
    check("R7 req_clr pulse", {8'b0, clr_seen}, 16'h0001);
    check("R7 host low", {15'b0, host_irq}, 16'h0);
    rd(4'hC, v); check("R7 status cleared", v, 16'h0);
  endtask

  task automatic t_timeout();
    logic [15:0] v;
    do_reset();
    @(negedge clk); tmo_set = 4'b1000;
    @(negedge clk); tmo_set = 0;
    rd(4'hC, v); check("R8 timeout set", v, 16'h8000);
    wr(4'hC, 16'h0F00);
    rd(4'hC, v); check("R8 error write no effect", v, 16'h8000);
    wr(4'hC, 16'h8000);
    rd(4'hC, v); check("R8 timeout cleared", v, 16'h0);
  endtask

  task automatic t_ack();
    logic [15:0] v;
    do_reset();
    wr(4'h4, 16'h0080);          // slot1 line1 level, bit 3
    set_req(3, 1);
    ack(2'd1, 6'd4);
    rd(4'hC, v); check("R9 other offset ignored", v, 16'h0008);
    clr_seen = 0;
    ack(2'd1, 6'd2);
    @(negedge clk);
    check("R9 ack req_clr", {8'b0, clr_seen}, 16'h0008);
    rd(4'hC, v); check("R9 ack clears", v, 16'h0);
    check("R9 host low", {15'b0, host_irq}, 16'h0);
    wr(4'h4, 16'h00A0);
    set_req(3, 0); set_req(3, 1);
    clr_seen = 0;
    ack(2'd1, 6'd2);
    @(negedge clk);
    check("R9 edge ack no clr", {8'b0, clr_seen}, 16'h0);
    rd(4'hC, v); check("R9 edge ack keeps", v, 16'h0008);
  endtask

  initial begin
    fork
      begin
        rst = 1;
        t_reset(); t_map(); t_disabled(); t_level(); t_edge();
        t_recompute(); t_w1c(); t_timeout(); t_ack();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule